// File: doc/BRIEF.md
# Vector Unit Issue Gate and Exception Logger

This block decides whether a vector coprocessor takes a new instruction from the scalar side. It also records the arithmetic exceptions that the vector pipelines raise. Each issue attempt gets an answer in the same cycle: accept, disabled fault, or stall. A privileged register port lets software switch the unit on or off. The same port clears the sticky exception status.

When an element raises an exception, two things are recorded. A sticky bit is set in the exception summary, with one bit per exception class. A flag write also goes to the matching element of the destination vector register. The unit then refuses later issues. The faulting instruction is not stopped: exceptions from its remaining elements keep being logged. Hardware errors also disable the unit, but they set a status bit of their own.

There are two synchronization requests. A memory barrier holds back issue until all memory traffic has drained. An exception sync holds back issue until all earlier vector work has finished and reported.

Top module: `vunit_gate`

## Requirements
- R1: After reset the unit is disabled, `exc_summary` is 0, `hw_err_flag` is 0, `issue_stall` is 0 and `flag_we` is 0.
- R2: While `issue_stall` is low, `issue_valid` gives `issue_accept` in the same cycle if the unit is enabled, and `issue_fault` if it is disabled. The two are never high together.
- R3: A privileged write to address 0 sets the enable state to `priv_wdata[0]`, starting from the next cycle.
- R4: An element exception whose filtered class is nonzero disables the unit from the next cycle. It wins over an enabling write in the same cycle.
- R5: The class bit positions are: bit 0 underflow, bit 1 integer overflow, bit 2 divide by zero, bit 3 invalid. The filtered class bits are ORed into `exc_summary` at the next edge, and they stay set.
- R6: With `exc_en` low, class bits 0 and 1 are dropped. An exception carrying only those bits changes nothing: no disable, no summary bit and no flag write.
- R7: One cycle after a reported exception, `flag_we` pulses for one cycle. With it, `flag_reg` and `flag_elem` carry the exception's register and element, and `flag_bits` carries the filtered class.
- R8: Exceptions that arrive while the unit is already disabled are still logged in the summary and still produce flag writes.
- R9: A `hw_err` pulse sets the sticky `hw_err_flag` and disables the unit. It leaves `exc_summary` unchanged.
- R10: A privileged write to address 1 clears the summary bits set in `priv_wdata[3:0]`. It clears `hw_err_flag` if `priv_wdata[4]` is set. A new exception bit arriving in the same cycle stays set.
- R11: A `msync_req` pulse while `mem_idle` is low raises `issue_stall` from the next cycle. The stall falls one cycle after `mem_idle` is first seen high. While stalled, an issue gets neither accept nor fault.
- R12: An `esync_req` pulse while `vec_idle` is low stalls issue in the same way, until one cycle after `vec_idle` is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Scalar side attempts an issue |
| issue_accept | output | 1 | Issue taken |
| issue_fault | output | 1 | Issue refused, disabled fault |
| issue_stall | output | 1 | Issue held back by a pending sync |
| msync_req | input | 1 | Memory barrier request pulse |
| esync_req | input | 1 | Exception sync request pulse |
| mem_idle | input | 1 | No vector or scalar memory reference outstanding |
| vec_idle | input | 1 | All accepted vector instructions finished and reported |
| exc_valid | input | 1 | Element exception from a pipeline |
| exc_en | input | 1 | Exception-enable bit of the instruction's control word |
| exc_class | input | 4 | Exception class bits |
| exc_reg | input | 4 | Destination vector register |
| exc_elem | input | 6 | Element index |
| hw_err | input | 1 | Hardware error pulse |
| priv_we | input | 1 | Privileged register write |
| priv_addr | input | 1 | 0 control, 1 status clear |
| priv_wdata | input | 5 | Write data |
| unit_enabled | output | 1 | Enable state |
| exc_summary | output | 4 | Sticky exception classes |
| hw_err_flag | output | 1 | Sticky hardware error |
| flag_we | output | 1 | Element flag write strobe |
| flag_reg | output | 4 | Flag write register |
| flag_elem | output | 6 | Flag write element |
| flag_bits | output | 4 | Flag write class bits |

## Verification
The assertions assume that `msync_req`, `esync_req` and `hw_err` are single-cycle pulses and that the exception inputs only matter while `exc_valid` is high. They also assume that the idle inputs describe traffic outside the block. The sticky-summary check relies on a privileged write to address 1 being the only way a bit can fall. The bench drives every input on the falling edge and returns each pulse low one cycle later. It changes the idle inputs only between sync requests, so each stall window has one clear start and one clear end.

// File: rtl/vgc_pkg.sv
package vgc_pkg;
    localparam int CLS_N   = 4;
    localparam int CLS_UFL = 0;
    localparam int CLS_IOV = 1;
    localparam int CLS_DVZ = 2;
    localparam int CLS_INV = 3;
    localparam int WD_W    = CLS_N + 1;
    localparam int CTL_EN  = 0;
    localparam int CLR_HW  = CLS_N;

    typedef enum logic {
        PRIV_CTRL = 1'b0,
        PRIV_STAT = 1'b1
    } priv_addr_e;
endpackage

// File: rtl/vgc_exc_log.sv
module vgc_exc_log
    import vgc_pkg::*;
#(
    parameter int REG_W  = 4,
    parameter int ELEM_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_valid_i,
    input  logic              exc_en_i,
    input  logic [CLS_N-1:0]  exc_class_i,
    input  logic [REG_W-1:0]  exc_reg_i,
    input  logic [ELEM_W-1:0] exc_elem_i,
    input  logic              hw_err_i,
    input  logic              clr_we_i,
    input  logic [WD_W-1:0]   clr_bits_i,
    output logic              disable_o,
    output logic [CLS_N-1:0]  summary_o,
    output logic              hw_flag_o,
    output logic              flag_we_o,
    output logic [REG_W-1:0]  flag_reg_o,
    output logic [ELEM_W-1:0] flag_elem_o,
    output logic [CLS_N-1:0]  flag_bits_o
);
    typedef struct packed {
        logic [CLS_N-1:0]  summary;
        logic              hw_flag;
        logic              flag_we;
        logic [REG_W-1:0]  flag_reg;
        logic [ELEM_W-1:0] flag_elem;
        logic [CLS_N-1:0]  flag_bits;
    } log_t;

    log_t             log_d, log_q;
    logic [CLS_N-1:0] keep_mask;
    logic [CLS_N-1:0] eff_cls;
    logic             hit;

    always_comb begin
        keep_mask = '1;
        if (!exc_en_i) begin
            keep_mask[CLS_UFL] = 1'b0;
            keep_mask[CLS_IOV] = 1'b0;
        end
        eff_cls = exc_class_i & keep_mask;
        hit     = exc_valid_i && (|eff_cls);

        log_d = log_q;
        if (clr_we_i) begin
            log_d.summary = log_q.summary & ~clr_bits_i[CLS_N-1:0];
            if (clr_bits_i[CLR_HW]) log_d.hw_flag = 1'b0;
        end
        if (hit)      log_d.summary = log_d.summary | eff_cls;
        if (hw_err_i) log_d.hw_flag = 1'b1;

        log_d.flag_we   = hit;
        log_d.flag_reg  = hit ? exc_reg_i  : '0;
        log_d.flag_elem = hit ? exc_elem_i : '0;
        log_d.flag_bits = hit ? eff_cls    : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) log_q <= '0;
        else        log_q <= log_d;
    end

    assign disable_o   = hit || hw_err_i;
    assign summary_o   = log_q.summary;
    assign hw_flag_o   = log_q.hw_flag;
    assign flag_we_o   = log_q.flag_we;
    assign flag_reg_o  = log_q.flag_reg;
    assign flag_elem_o = log_q.flag_elem;
    assign flag_bits_o = log_q.flag_bits;

    // R7
    flag_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid_i && exc_en_i && (|exc_class_i)) |=> flag_we_o);

    // R6
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid_i && !exc_en_i && !exc_class_i[CLS_DVZ] && !exc_class_i[CLS_INV])
        |=> !flag_we_o);

    // R5
    sticky_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we_i |=> ((summary_o & $past(summary_o)) == $past(summary_o)));
endmodule

// File: rtl/vgc_issue_gate.sv
module vgc_issue_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic issue_valid_i,
    input  logic ctrl_we_i,
    input  logic ctrl_en_i,
    input  logic disable_i,
    input  logic msync_req_i,
    input  logic esync_req_i,
    input  logic mem_idle_i,
    input  logic vec_idle_i,
    output logic accept_o,
    output logic fault_o,
    output logic stall_o,
    output logic enabled_o
);
    typedef struct packed {
        logic enabled;
        logic msync_pend;
        logic esync_pend;
    } gate_t;

    gate_t gate_d, gate_q;

    always_comb begin
        gate_d = gate_q;
        if (ctrl_we_i) gate_d.enabled = ctrl_en_i;
        if (disable_i) gate_d.enabled = 1'b0;
        gate_d.msync_pend = (gate_q.msync_pend || msync_req_i) && !mem_idle_i;
        gate_d.esync_pend = (gate_q.esync_pend || esync_req_i) && !vec_idle_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) gate_q <= '0;
        else        gate_q <= gate_d;
    end

    assign stall_o   = gate_q.msync_pend || gate_q.esync_pend;
    assign accept_o  = issue_valid_i && !stall_o && gate_q.enabled;
    assign fault_o   = issue_valid_i && !stall_o && !gate_q.enabled;
    assign enabled_o = gate_q.enabled;

    // R4
    self_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disable_i |=> !enabled_o);

    // R2
    resp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept_o && fault_o));

    // R11
    msync_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msync_req_i && !mem_idle_i) |=> stall_o);

    // R12
    esync_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (esync_req_i && !vec_idle_i) |=> stall_o);
endmodule

// File: rtl/vunit_gate.sv
module vunit_gate
    import vgc_pkg::*;
#(
    parameter int NUM_VREG = 16,
    parameter int NUM_ELEM = 64,
    localparam int REG_W   = $clog2(NUM_VREG),
    localparam int ELEM_W  = $clog2(NUM_ELEM)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    output logic              issue_accept,
    output logic              issue_fault,
    output logic              issue_stall,
    input  logic              msync_req,
    input  logic              esync_req,
    input  logic              mem_idle,
    input  logic              vec_idle,
    input  logic              exc_valid,
    input  logic              exc_en,
    input  logic [CLS_N-1:0]  exc_class,
    input  logic [REG_W-1:0]  exc_reg,
    input  logic [ELEM_W-1:0] exc_elem,
    input  logic              hw_err,
    input  logic              priv_we,
    input  logic              priv_addr,
    input  logic [WD_W-1:0]   priv_wdata,
    output logic              unit_enabled,
    output logic [CLS_N-1:0]  exc_summary,
    output logic              hw_err_flag,
    output logic              flag_we,
    output logic [REG_W-1:0]  flag_reg,
    output logic [ELEM_W-1:0] flag_elem,
    output logic [CLS_N-1:0]  flag_bits
);
    logic ctrl_we, stat_we, disable_evt;

    assign ctrl_we = priv_we && (priv_addr == PRIV_CTRL);
    assign stat_we = priv_we && (priv_addr == PRIV_STAT);

    vgc_exc_log #(.REG_W(REG_W), .ELEM_W(ELEM_W)) log_i (
        .clk(clk), .rst_n(rst_n),
        .exc_valid_i(exc_valid), .exc_en_i(exc_en), .exc_class_i(exc_class),
        .exc_reg_i(exc_reg), .exc_elem_i(exc_elem), .hw_err_i(hw_err),
        .clr_we_i(stat_we), .clr_bits_i(priv_wdata),
        .disable_o(disable_evt), .summary_o(exc_summary), .hw_flag_o(hw_err_flag),
        .flag_we_o(flag_we), .flag_reg_o(flag_reg), .flag_elem_o(flag_elem),
        .flag_bits_o(flag_bits)
    );

    vgc_issue_gate gate_i (
        .clk(clk), .rst_n(rst_n),
        .issue_valid_i(issue_valid), .ctrl_we_i(ctrl_we),
        .ctrl_en_i(priv_wdata[CTL_EN]), .disable_i(disable_evt),
        .msync_req_i(msync_req), .esync_req_i(esync_req),
        .mem_idle_i(mem_idle), .vec_idle_i(vec_idle),
        .accept_o(issue_accept), .fault_o(issue_fault),
        .stall_o(issue_stall), .enabled_o(unit_enabled)
    );

    // R9
    hw_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_err |=> (hw_err_flag && !unit_enabled));
endmodule

// File: tb/vunit_gate_tb.sv
`timescale 1ns/1ps
module vunit_gate_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic issue_valid = 0, msync_req = 0, esync_req = 0, mem_idle = 1, vec_idle = 1;
    logic exc_valid = 0, exc_en = 1, hw_err = 0, priv_we = 0, priv_addr = 0;
    logic [3:0] exc_class = 0, exc_reg = 0;
    logic [5:0] exc_elem = 0;
    logic [4:0] priv_wdata = 0;
    logic issue_accept, issue_fault, issue_stall, unit_enabled, hw_err_flag, flag_we;
    logic [3:0] exc_summary, flag_reg, flag_bits;
    logic [5:0] flag_elem;
    int n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    vunit_gate dut_i (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok || act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic priv_write(input logic a, input logic [4:0] d);
        priv_we = 1; priv_addr = a; priv_wdata = d;
        tick();
        priv_we = 0; priv_wdata = 0;
    endtask

    task automatic raise(input logic en, input logic [3:0] cls, input logic [3:0] r, input logic [5:0] e);
        exc_valid = 1; exc_en = en; exc_class = cls; exc_reg = r; exc_elem = e;
        tick();
        exc_valid = 0; exc_class = 0; exc_en = 1;
    endtask

    task automatic t_reset();
        chk(1, "R1 enabled", unit_enabled, 0);
        chk(1, "R1 summary", exc_summary, 0);
        chk(1, "R1 hwflag", hw_err_flag, 0);
        chk(1, "R1 stall", issue_stall, 0);
        chk(1, "R1 flag_we", flag_we, 0);
    endtask

    task automatic t_issue();
        issue_valid = 1; #0.5;
        chk(1, "R2 fault when disabled", issue_fault, 1);
        chk(1, "R2 no accept when disabled", issue_accept, 0);
        issue_valid = 0;
        priv_write(1'b0, 5'h01);
        chk(1, "R3 enabled after write", unit_enabled, 1);
        issue_valid = 1; #0.5;
        chk(1, "R2 accept when enabled", issue_accept, 1);
        chk(1, "R2 no fault when enabled", issue_fault, 0);
        issue_valid = 0;
        priv_write(1'b0, 5'h00);
        chk(1, "R3 disabled by write", unit_enabled, 0);
        priv_write(1'b0, 5'h01);
    endtask

    task automatic t_exception();
        raise(1'b1, 4'b0101, 4'd9, 6'd33);
        chk(1, "R4 self disable", unit_enabled, 0);
        chk(1, "R5 summary", exc_summary, 4'b0101);
        chk(1, "R7 flag_we", flag_we, 1);
        chk(1, "R7 flag_reg", flag_reg, 9);
        chk(1, "R7 flag_elem", flag_elem, 33);
        chk(1, "R7 flag_bits", flag_bits, 4'b0101);
        tick();
        chk(1, "R7 single pulse", flag_we, 0);
        raise(1'b1, 4'b1000, 4'd9, 6'd34);
        chk(1, "R8 logged while disabled", exc_summary, 4'b1101);
        chk(1, "R8 flag while disabled", flag_we, 1);
        chk(1, "R8 flag_elem", flag_elem, 34);
        priv_write(1'b1, 5'h0F);
        chk(1, "R10 summary cleared", exc_summary, 0);
    endtask

    task automatic t_enable_race();
        priv_we = 1; priv_addr = 0; priv_wdata = 5'h01;
        exc_valid = 1; exc_en = 1; exc_class = 4'b0100;
        tick();
        priv_we = 0; exc_valid = 0; exc_class = 0;
        chk(1, "R4 exception beats enable", unit_enabled, 0);
        priv_write(1'b1, 5'h0F);
    endtask

    task automatic t_masking();
        priv_write(1'b0, 5'h01);
        raise(1'b0, 4'b0011, 4'd2, 6'd5);
        chk(1, "R6 no disable", unit_enabled, 1);
        chk(1, "R6 no summary", exc_summary, 0);
        chk(1, "R6 no flag", flag_we, 0);
        raise(1'b0, 4'b1011, 4'd2, 6'd6);
        chk(1, "R6 partial mask summary", exc_summary, 4'b1000);
        chk(1, "R6 partial mask bits", flag_bits, 4'b1000);
        priv_write(1'b1, 5'h0F);
        priv_write(1'b0, 5'h01);
        raise(1'b1, 4'b0011, 4'd2, 6'd7);
        chk(1, "R5 unmasked low classes", exc_summary, 4'b0011);
        priv_write(1'b1, 5'h0F);
    endtask

    task automatic t_hwerr_clear();
        priv_write(1'b0, 5'h01);
        hw_err = 1; tick(); hw_err = 0;
        chk(1, "R9 hw flag", hw_err_flag, 1);
        chk(1, "R9 disabled", unit_enabled, 0);
        chk(1, "R9 summary untouched", exc_summary, 0);
        raise(1'b1, 4'b0110, 4'd1, 6'd1);
        priv_write(1'b1, 5'b00010);
        chk(1, "R10 partial clear", exc_summary, 4'b0100);
        chk(1, "R10 hw kept", hw_err_flag, 1);
        priv_we = 1; priv_addr = 1; priv_wdata = 5'b10100;
        exc_valid = 1; exc_class = 4'b0100;
        tick();
        priv_we = 0; exc_valid = 0; exc_class = 0;
        chk(1, "R10 new bit survives clear", exc_summary, 4'b0100);
        chk(1, "R10 hw cleared", hw_err_flag, 0);
        priv_write(1'b1, 5'h0F);
    endtask

    task automatic t_sync(input bit mem);
        priv_write(1'b0, 5'h01);
        if (mem) begin mem_idle = 0; msync_req = 1; end
        else     begin vec_idle = 0; esync_req = 1; end
        tick();
        msync_req = 0; esync_req = 0;
        chk(1, mem ? "R11 stall raised" : "R12 stall raised", issue_stall, 1);
        issue_valid = 1; #0.5;
        chk(1, mem ? "R11 no accept" : "R12 no accept", issue_accept, 0);
        chk(1, mem ? "R11 no fault" : "R12 no fault", issue_fault, 0);
        issue_valid = 0;
        tick(); tick();
        chk(1, mem ? "R11 still stalled" : "R12 still stalled", issue_stall, 1);
        mem_idle = 1; vec_idle = 1;
        tick();
        chk(1, mem ? "R11 stall released" : "R12 stall released", issue_stall, 0);
        issue_valid = 1; #0.5;
        chk(1, mem ? "R11 accept after" : "R12 accept after", issue_accept, 1);
        issue_valid = 0;
        if (mem) msync_req = 1; else esync_req = 1;
        tick();
        msync_req = 0; esync_req = 0;
        chk(1, mem ? "R11 idle no stall" : "R12 idle no stall", issue_stall, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        tick();
        t_reset();
        t_issue();
        t_exception();
        t_enable_race();
        t_masking();
        t_hwerr_clear();
        t_sync(1'b1);
        t_sync(1'b0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule